// File: doc/BRIEF.md
# Fractional-N Delta-Sigma Modulator

This block produces one integer division value per phase-detector cycle for a multi-modulus feedback divider. Its inputs are an integer part N, a fractional numerator and denominator, an order code, a dither code and a flag that sets the denominator width. It advances once per clock (the phase-detector clock). It drives a registered divide value whose long-term mean is N + NUM/DEN.

Inside are cascaded first-order accumulators that wrap modulo DEN, so any modulus is allowed, including moduli that are not powers of two. A difference network merges their carries into a second, third or fourth order noise-shaped correction. The first accumulator can receive a pseudo-random bit from an LFSR as dither. A combinational checker flags configurations that the divider cannot realise. While the flag is set, the output stays at N and every accumulator is held cleared.

Top module: `fracn_dsm`

## Requirements
- R1: While rst_n is low at a clock edge, div_val becomes 0 and cfg_err becomes 0.
- R2: With order_sel = 1 (integer mode), div_val equals int_part one clock after the inputs are applied, whatever the numerator and denominator are. A zero denominator is accepted in this mode.
- R3: cfg_err rises one clock after int_part is below 48, in 52..54, or above 2039. Values 48..51 also raise it unless order_sel = 1.
- R4: Outside integer mode, cfg_err rises one clock after the effective denominator is 0 or the effective numerator is not below it.
- R5: While cfg_err is high, div_val equals the int_part of the previous clock.
- R6: order_sel = 2, 3 and 0 select second, third and fourth order. With dither off, and counting from reset release, the sum of (div_val - N) at every multiple of DEN cycles differs from (cycles/DEN)×NUM by no more than 2^(order-1).
- R7: In fractional operation every div_val lies in N-(2^(order-1)-1) .. N+2^(order-1).
- R8: When wide_den = 0, only bits 11:0 of the numerator and denominator take effect and bits 21:12 are ignored. When wide_den = 1, all 22 bits take effect.
- R9: dither_sel = 3 turns dither off and code 1 (reserved) acts the same as 3. Code 2 (strong) adds one LFSR bit to the first accumulator on every cycle. Code 0 (weak) adds a bit only when three LFSR bits are all ones, about 1 cycle in 8. Dither raises the mean, and strong raises it more than weak.
- R10: When the effective numerator is 0, no dither is injected and div_val stays at N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_part | input | 11 | Integer part N of the division ratio |
| frac_num | input | 22 | Fractional numerator |
| frac_den | input | 22 | Fractional denominator (modulus) |
| order_sel | input | 2 | 0 fourth, 1 integer, 2 second, 3 third order |
| dither_sel | input | 2 | 0 weak, 1 reserved (off), 2 strong, 3 off |
| wide_den | input | 1 | 1 uses all 22 bits, 0 uses the low 12 bits |
| div_val | output | 11 | Division value for the current cycle |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
Integer mode is swept over every 11-bit integer value. This exposes a shifted legality window, such as 52..54 being accepted or 48..51 being rejected in integer mode, as a wrong flag. For each order, the cumulative deviation is checked at every multiple of DEN. A stage whose residue comes from the wrong cycle, or a wrap that uses a power-of-two modulus, makes that deviation grow without bound. Two runs differ only in bits 21:12 of the operands with wide_den low, and must produce identical weighted checksums; a design that leaks those bits would give different sequences. The dither runs compare the mean bias of strong, weak, reserved and off modes, and NUM = 0 must give a constant output, which fails if dither suppression is missing.

// File: rtl/fracn_dsm_pkg.sv
// Package: shared codes and limits for the fractional-N modulator.
// Assumes the 11-bit integer range and the 2-bit order/dither codes below.
package fracn_dsm_pkg;
    typedef enum logic [1:0] {
        ORD_FOURTH  = 2'd0,
        ORD_INTEGER = 2'd1,
        ORD_SECOND  = 2'd2,
        ORD_THIRD   = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        DITH_WEAK   = 2'd0,
        DITH_RSVD   = 2'd1,
        DITH_STRONG = 2'd2,
        DITH_OFF    = 2'd3
    } dither_e;

    localparam int N_FLOOR     = 48;   // below: never legal
    localparam int N_GAP_LO    = 52;   // 52..54 never legal
    localparam int N_GAP_HI    = 54;
    localparam int N_FRAC_MIN  = 55;   // lowest value usable with a fraction
    localparam int N_CEIL      = 2039; // above: never legal

    // Number of active accumulator stages for an order code.
    function automatic int unsigned stage_count(input logic [1:0] code);
        case (order_e'(code))
            ORD_SECOND: return 2;
            ORD_THIRD:  return 3;
            ORD_FOURTH: return 4;
            default:    return 0;
        endcase
    endfunction
endpackage

// File: rtl/fracn_cfg_check.sv
// Configuration checker: masks operands to the selected width and flags
// integer values and fractions the divider cannot realise.
// Assumes FRAC_W > LOW_W. Purely combinational.
module fracn_cfg_check
    import fracn_dsm_pkg::*;
#(
    parameter int INT_W  = 11,
    parameter int FRAC_W = 22,
    parameter int LOW_W  = 12
) (
    input  logic [INT_W-1:0]  int_part,
    input  logic [FRAC_W-1:0] num_raw,
    input  logic [FRAC_W-1:0] den_raw,
    input  logic              int_mode,
    input  logic              wide_den,
    output logic [FRAC_W-1:0] num_eff,
    output logic [FRAC_W-1:0] den_eff,
    output logic              illegal
);
    localparam int HI_W = FRAC_W - LOW_W;

    logic int_bad;
    logic frac_bad;

    // Width selection and legality decode.
    always_comb begin
        num_eff  = wide_den ? num_raw : {{HI_W{1'b0}}, num_raw[LOW_W-1:0]};
        den_eff  = wide_den ? den_raw : {{HI_W{1'b0}}, den_raw[LOW_W-1:0]};
        int_bad  = (int_part < INT_W'(N_FLOOR))
                 || ((int_part >= INT_W'(N_GAP_LO)) && (int_part <= INT_W'(N_GAP_HI)))
                 || (int_part > INT_W'(N_CEIL))
                 || (!int_mode && (int_part < INT_W'(N_FRAC_MIN)));
        frac_bad = !int_mode && ((den_eff == '0) || (num_eff >= den_eff));
        illegal  = int_bad || frac_bad;
    end
endmodule

// File: rtl/fracn_mash_stage.sv
// One first-order accumulator stage with modulo-'modulus' wraparound.
// Emits a carry when the sum reaches the modulus and exposes the post-update
// residue for the next stage. Assumes acc_q, addend < modulus while enabled.
module fracn_mash_stage #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] addend,
    input  logic         cin,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] resid,
    output logic         carry
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;
    logic [W:0]   wrapped;

    // Add, then subtract the modulus once on overflow.
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, addend} + {{W{1'b0}}, cin};
        carry   = en && (sum >= {1'b0, modulus});
        wrapped = carry ? (sum - {1'b0, modulus}) : sum;
        resid   = en ? wrapped[W-1:0] : '0;
    end

    // Accumulator state; cleared whenever the stage is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) acc_q <= '0;
        else               acc_q <= resid;
    end

    AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc_q < modulus && addend < modulus) |=> (acc_q < $past(modulus))); // R6
endmodule

// File: rtl/fracn_dither_lfsr.sv
// Free-running Fibonacci LFSR giving a dither bit for the first stage:
// every cycle in strong mode, when WEAK_BITS low bits are all ones in weak
// mode, never otherwise or when 'allow' is low. Assumes TAP < W.
module fracn_dither_lfsr #(
    parameter int W         = 23,
    parameter int TAP       = 18,
    parameter int WEAK_BITS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       allow,
    output logic       dbit
);
    import fracn_dsm_pkg::*;

    logic [W-1:0] lfsr_q;

    // Shift register with feedback from the last stage and the tap.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= {{(W-1){1'b0}}, 1'b1};
        else        lfsr_q <= {lfsr_q[W-2:0], lfsr_q[W-1] ^ lfsr_q[TAP-1]};
    end

    // Mode select for the injected bit.
    always_comb begin
        case (dither_e'(mode))
            DITH_STRONG: dbit = allow && lfsr_q[0];
            DITH_WEAK:   dbit = allow && (&lfsr_q[WEAK_BITS-1:0]);
            default:     dbit = 1'b0;
        endcase
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_q != '0)); // R9
endmodule

// File: rtl/fracn_dsm.sv
// Fractional-N delta-sigma modulator, top level. Cascaded modulo-DEN
// accumulators, combined through a difference network, give the per-cycle
// correction added to int_part. Assumes configuration changes are followed
// by reset if exact averaging from zero state is required.
module fracn_dsm
    import fracn_dsm_pkg::*;
#(
    parameter int INT_W  = 11,
    parameter int FRAC_W = 22,
    parameter int LOW_W  = 12,
    parameter int STAGES = 4,
    parameter int LFSR_W = 23,
    parameter int LFSR_TAP = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_part,
    input  logic [FRAC_W-1:0] frac_num,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic [1:0]        order_sel,
    input  logic [1:0]        dither_sel,
    input  logic              wide_den,
    output logic [INT_W-1:0]  div_val,
    output logic              cfg_err
);
    localparam int SW = $clog2(STAGES) + 4;   // signed width of the combiner
    localparam int EW = INT_W + 2;            // width of the extended sum

    logic [FRAC_W-1:0]     num_eff;
    logic [FRAC_W-1:0]     den_eff;
    logic                  illegal;
    logic                  int_mode;
    logic                  active;
    logic                  dbit;
    int unsigned           n_stages;
    logic [STAGES-1:0]     carry;
    logic [STAGES-1:0]     st_en;
    logic [FRAC_W-1:0]     resid [STAGES];
    logic signed [SW-1:0]  s   [STAGES];
    logic signed [SW-1:0]  s_d [1:STAGES-1];
    logic signed [EW-1:0]  sum_ext;
    logic [INT_W-1:0]      div_next;

    // Mode decode.
    always_comb begin
        int_mode = (order_e'(order_sel) == ORD_INTEGER);
        active   = !int_mode && !illegal;
        n_stages = stage_count(order_sel);
    end

    fracn_cfg_check #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LOW_W(LOW_W)) u_cfg (
        .int_part (int_part),
        .num_raw  (frac_num),
        .den_raw  (frac_den),
        .int_mode (int_mode),
        .wide_den (wide_den),
        .num_eff  (num_eff),
        .den_eff  (den_eff),
        .illegal  (illegal)
    );

    fracn_dither_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .WEAK_BITS(3)) u_dith (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (dither_sel),
        .allow (active && (num_eff != '0)),
        .dbit  (dbit)
    );

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            assign st_en[k] = active && (k < n_stages);
            if (k == 0) begin : g_first
                fracn_mash_stage #(.W(FRAC_W)) u_st (
                    .clk(clk), .rst_n(rst_n), .en(st_en[k]),
                    .addend(num_eff), .cin(dbit), .modulus(den_eff),
                    .resid(resid[k]), .carry(carry[k])
                );
            end else begin : g_next
                fracn_mash_stage #(.W(FRAC_W)) u_st (
                    .clk(clk), .rst_n(rst_n), .en(st_en[k]),
                    .addend(resid[k-1]), .cin(1'b0), .modulus(den_eff),
                    .resid(resid[k]), .carry(carry[k])
                );
            end
        end
    endgenerate

    // Difference network: s[k] = c[k] + s[k+1] - s[k+1] delayed.
    always_comb begin
        s[STAGES-1] = {{(SW-1){1'b0}}, carry[STAGES-1]};
        for (int j = STAGES - 2; j >= 0; j--) begin
            s[j] = $signed({{(SW-1){1'b0}}, carry[j]}) + s[j+1] - s_d[j+1];
        end
        sum_ext  = $signed({2'b00, int_part}) + EW'(s[0]);
        div_next = active ? sum_ext[INT_W-1:0] : int_part;
    end

    // Delay registers of the combiner; cleared when fractional path is idle.
    always_ff @(posedge clk) begin
        for (int j = 1; j < STAGES; j++) begin
            if (!rst_n || !active) s_d[j] <= '0;
            else                   s_d[j] <= s[j];
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val <= '0;
            cfg_err <= 1'b0;
        end else begin
            div_val <= div_next;
            cfg_err <= illegal;
        end
    end

    AST_INT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && !illegal) |=> (div_val == $past(int_part))); // R2
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (cfg_err && div_val == $past(int_part))); // R5
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && n_stages >= 2) |=>
        ((int'(div_val) - int'($past(int_part)) <= (1 << ($past(n_stages) - 1)))
         && (int'(div_val) - int'($past(int_part)) >= 1 - (1 << ($past(n_stages) - 1))))); // R7
    AST_NO_DITHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (num_eff == '0) |-> !dbit); // R10
endmodule

// File: tb/fracn_dsm_bench.sv
`timescale 1ns/1ps
module fracn_dsm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] int_part = '0;
    logic [21:0] frac_num = '0;
    logic [21:0] frac_den = '0;
    logic [1:0]  order_sel = 2'd1;
    logic [1:0]  dither_sel = 2'd3;
    logic        wide_den = 1'b0;
    logic [10:0] div_val;
    logic        cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    fracn_dsm u_fracn_dsm (
        .clk(clk), .rst_n(rst_n), .int_part(int_part), .frac_num(frac_num),
        .frac_den(frac_den), .order_sel(order_sel), .dither_sel(dither_sel),
        .wide_den(wide_den), .div_val(div_val), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit n_illegal(input int n, input bit intm);
        return (n < 48) || (n >= 52 && n <= 54) || (n > 2039) || (!intm && n < 55);
    endfunction

    function automatic int hi_of(input int ord);
        return (ord == 2) ? 2 : (ord == 3) ? 4 : 8;
    endfunction

    task automatic setup(input int n, input longint num, input longint den,
                         input int ord, input int dith, input bit wide);
        @(negedge clk);
        rst_n = 1'b0;
        int_part = 11'(n); frac_num = 22'(num); frac_den = 22'(den);
        order_sel = 2'(ord); dither_sel = 2'(dith); wide_den = wide;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run a fractional configuration; num_e/den_e are the effective operands.
    task automatic run_frac(input int n, input longint num, input longint den,
                            input longint num_e, input longint den_e,
                            input int ord, input int dith, input bit wide, input int cycles,
                            output longint sum, output longint wsum);
        int hi = hi_of(ord);
        bit rng_ok = 1;
        bit dev_ok = 1;
        longint bad_v = 0;
        longint dev = 0;
        longint bad_dev = 0;
        setup(n, num, den, ord, dith, wide);
        sum = 0; wsum = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            sum  += longint'(div_val);
            wsum += longint'(div_val) * longint'((i % 97) + 1);
            if ((int'(div_val) - n > hi) || (int'(div_val) - n < 1 - hi)) begin
                rng_ok = 0; bad_v = longint'(div_val);
            end
            if ((((i + 1) % den_e) == 0) && (dith == 3 || dith == 1 || num_e == 0)) begin
                dev = sum - longint'(n) * (i + 1) - ((i + 1) / den_e) * num_e;
                if (dev > hi || dev < -hi) begin dev_ok = 0; bad_dev = dev; end
            end
        end
        chk(rng_ok, "R7 output range", rng_ok ? n : bad_v, n);
        chk(!cfg_err, "R4 legal config not flagged", cfg_err, 0);
        if (dith == 3 || dith == 1 || num_e == 0)
            chk(dev_ok, "R6 cumulative deviation", bad_dev, 0);
    endtask

    initial begin
        longint s_a, w_a, s_b, w_b, s_off, w_off, s_w, w_w, s_s, w_s, s_r, w_r;
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk(div_val == 0, "R1 div_val in reset", div_val, 0);
        chk(cfg_err == 0, "R1 cfg_err in reset", cfg_err, 0);

        // R2/R3: integer mode sweep over every integer value
        setup(100, 0, 0, 1, 3, 0);
        for (int n = 0; n < 2048; n++) begin
            int_part = 11'(n);
            frac_num = 22'(n * 37);
            @(negedge clk);
            chk(div_val == 11'(n), "R2 integer passthrough", div_val, n);
            chk(cfg_err == n_illegal(n, 1), "R3 integer legality", cfg_err, n_illegal(n, 1));
        end

        // R3/R5: legality window in fractional mode, output held at N when flagged
        setup(60, 1, 3, 2, 3, 0);
        for (int n = 44; n <= 60; n++) begin
            int_part = 11'(n);
            @(negedge clk);
            chk(cfg_err == n_illegal(n, 0), "R3 fractional legality", cfg_err, n_illegal(n, 0));
            if (n_illegal(n, 0))
                chk(div_val == 11'(n), "R5 hold at N when flagged", div_val, n);
        end

        // R4: zero denominator and numerator not below denominator
        setup(200, 5, 0, 3, 3, 0);
        @(negedge clk);
        chk(cfg_err == 1, "R4 zero denominator", cfg_err, 1);
        chk(div_val == 200, "R5 zero denominator hold", div_val, 200);
        setup(200, 100, 100, 0, 3, 0);
        @(negedge clk);
        chk(cfg_err == 1, "R4 numerator equals denominator", cfg_err, 1);
        setup(200, 7, 0, 1, 3, 0);
        @(negedge clk);
        chk(cfg_err == 0, "R2 zero denominator in integer mode", cfg_err, 0);

        // R6/R7: each order, several fractions
        run_frac(173, 61, 100, 61, 100, 2, 3, 0, 1000, s_a, w_a);
        run_frac(173, 61, 100, 61, 100, 3, 3, 0, 1000, s_a, w_a);
        run_frac(173, 61, 100, 61, 100, 0, 3, 0, 1000, s_a, w_a);
        run_frac(600, 999, 1000, 999, 1000, 3, 3, 0, 3000, s_a, w_a);
        run_frac(2039, 4999, 5000, 4999, 5000, 0, 3, 1, 5000, s_a, w_a);  // R8 wide
        run_frac(55, 1, 7, 1, 7, 0, 3, 0, 700, s_a, w_a);

        // R8: upper bits ignored in narrow mode
        run_frac(300, 61, 100, 61, 100, 3, 3, 0, 1000, s_a, w_a);
        run_frac(300, (22'h3FF << 12) | 61, (22'h155 << 12) | 100, 61, 100, 3, 3, 0, 1000, s_b, w_b);
        chk(w_a == w_b, "R8 narrow mode ignores upper bits", w_b, w_a);

        // R9: dither modes
        run_frac(300, 1, 64, 1, 64, 2, 3, 0, 6400, s_off, w_off);
        run_frac(300, 1, 64, 1, 64, 2, 1, 0, 6400, s_r, w_r);
        chk(w_r == w_off, "R9 reserved code acts as off", w_r, w_off);
        run_frac(300, 1, 64, 1, 64, 2, 0, 0, 6400, s_w, w_w);
        run_frac(300, 1, 64, 1, 64, 2, 2, 0, 6400, s_s, w_s);
        chk((s_w - s_off) > 0, "R9 weak dither raises mean", s_w - s_off, 1);
        chk((s_s - s_off) > (s_w - s_off), "R9 strong exceeds weak", s_s - s_off, s_w - s_off);

        // R10: no dither with zero numerator
        run_frac(400, 0, 50, 0, 50, 0, 2, 0, 500, s_a, w_a);
        chk(s_a == 400 * 500, "R10 zero numerator stays at N", s_a, 400 * 500);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule